// File: doc/BRIEF.md
# Slow-Clock Independent Watchdog

This block is a down-counting watchdog whose counter lives in its own slow clock domain. It raises a reset request when software fails to refresh it within a programmed time. Software talks to it from the bus clock domain through a small valid/write register port. Four registers are exposed:

- a key register that takes commands;
- a prescaler code register;
- a 12-bit reload register;
- a status register with two busy flags.

Every configuration write and every refresh crosses into the slow domain through a toggle handshake. The matching busy flag stays high until the slow side has taken the value. Software polls the status register before it relies on a new setting.

Once started, the watchdog cannot be stopped by any command or write. Only a reset of both domains returns it to idle. While it runs, the block holds an output high that keeps the slow oscillator forced on.

When the counter expires, the reset request pulses for one slow-clock cycle. The counter then reloads and keeps counting.

Top module: `slowclk_watchdog`

## Requirements
- R1: The divider ratio is 4 << code, where code is bits [2:0] written at address 1. Codes 6 and 7 both give the largest ratio, 256.
- R2: While running, successive reset-request pulses are exactly ratio × (reload + 1) slow cycles apart. Each pulse lasts one slow cycle, and counting continues after it.
- R3: A write to address 1 (prescaler) or address 2 (reload) is ignored unless write access is enabled. Write access is enabled by writing 16'h5555 to address 0 (key), and it stays enabled only until a later key write clears it.
- R4: Address 3 reads bit 0 as prescaler-busy and bit 1 as reload-busy. A busy bit is set from an accepted write until the slow domain has taken the value. A write to a register whose busy bit is set is ignored.
- R5: Key 16'hCCCC starts the watchdog. From the bus cycle after the write, `osc_keep_on` is high, and no later write stops it or the reset-request pulses.
- R6: Key 16'hAAAA refreshes: it reloads the counter with the current reload value, so no pulse occurs while refreshes arrive in time. It also clears write access.
- R7: A key value other than the three commands clears write access and has no other effect.
- R8: After reset, the code reads 0, the reload reads 16'h0FFF, the status reads 0, and both outputs are low with no pulses. Addresses 1 and 2 read back the last accepted value.
- R9: A refresh that reaches the counter in the same slow cycle as an expiry suppresses that pulse, so no pulse gap is ever shorter than the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-port clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| slow_clk | input | 1 | Slow counting clock |
| slow_rst_n | input | 1 | Synchronous active-low reset, slow domain |
| bus_valid | input | 1 | Access strobe, one bus cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 key, 1 prescaler code, 2 reload, 3 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| osc_keep_on | output | 1 | Holds the slow oscillator on once started |
| wdg_reset_req | output | 1 | One-slow-cycle reset request on expiry |

## Verification
A refresh and a counter expiry can land in the same slow cycle. The bench provokes this by sweeping the issue time of a refresh across a whole short period in steps of five bus cycles, so one of the refreshes meets the zero-count tick. It judges the outcome by demanding that no pulse gap falls below ratio × (reload + 1) and that periodic pulsing resumes afterwards. An assertion in the counter forbids a pulse in the cycle after a refresh meets an expiry tick.

// File: rtl/slowwdg_pkg.sv
// Shared constants for the slow-clock watchdog: command keys and register map.
package slowwdg_pkg;
    localparam int KEY_W = 16;

    localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_KICK   = 16'hAAAA;

    typedef enum logic [1:0] {
        A_KEY    = 2'd0,
        A_PRESC  = 2'd1,
        A_RELOAD = 2'd2,
        A_STATUS = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/slowwdg_sync.sv
// Multi-flop synchronizer for level signals crossing into clk.
// Assumes the input is a level or a toggle that is stable for several destination cycles.
module slowwdg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/slowwdg_xfer.sv
// Toggle-handshake transfer of one value from the bus domain (a) to the slow domain (b).
// A load while busy is dropped; the bus-side held value doubles as the readback copy.
// Assumes both domains leave reset together.
module slowwdg_xfer #(
    parameter int             W       = 12,
    parameter logic [W-1:0]   RST_VAL = '0,
    parameter int             STAGES  = 2
) (
    input  logic         a_clk,
    input  logic         a_rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    output logic         busy_o,
    output logic [W-1:0] hold_o,
    input  logic         b_clk,
    input  logic         b_rst_n,
    output logic         upd_o,
    output logic [W-1:0] data_o
);
    logic         req_tgl;
    logic         ack_a;
    logic         req_b;
    logic         seen_b;

    // Bus side: accept a new value only when no transfer is in flight.
    always_ff @(posedge a_clk) begin
        if (!a_rst_n) begin
            req_tgl <= 1'b0;
            hold_o  <= RST_VAL;
        end else if (load_i && !busy_o) begin
            req_tgl <= ~req_tgl;
            hold_o  <= data_i;
        end
    end

    assign busy_o = req_tgl ^ ack_a;

    slowwdg_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
        .clk(b_clk), .rst_n(b_rst_n), .d(req_tgl), .q(req_b)
    );

    // Slow side: capture the held value when the request toggle changes.
    always_ff @(posedge b_clk) begin
        if (!b_rst_n) begin
            seen_b <= 1'b0;
            upd_o  <= 1'b0;
            data_o <= RST_VAL;
        end else begin
            seen_b <= req_b;
            upd_o  <= req_b ^ seen_b;
            if (req_b ^ seen_b) data_o <= hold_o;
        end
    end

    slowwdg_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
        .clk(a_clk), .rst_n(a_rst_n), .d(seen_b), .q(ack_a)
    );

    // R4: a load arriving while busy must leave the held value untouched.
    a_r4_hold_while_busy: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        (load_i && busy_o) |=> $stable(hold_o));
endmodule

// File: rtl/slowwdg_regs.sv
// Bus-domain register port: key decoding, write-access lock, start latch and readback.
// Assumes one-cycle accesses with combinational read data.
module slowwdg_regs
    import slowwdg_pkg::*;
#(
    parameter int CODE_W   = 3,
    parameter int RELOAD_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_i,
    input  logic                write_i,
    input  logic [1:0]          addr_i,
    input  logic [KEY_W-1:0]    wdata_i,
    output logic [KEY_W-1:0]    rdata_o,
    input  logic [CODE_W-1:0]   presc_q_i,
    input  logic [RELOAD_W-1:0] reload_q_i,
    input  logic                ps_busy_i,
    input  logic                rl_busy_i,
    output logic                presc_load_o,
    output logic                reload_load_o,
    output logic                kick_load_o,
    output logic                started_o
);
    logic      wr;
    logic      wr_en;
    reg_addr_e addr;

    assign addr = reg_addr_e'(addr_i);
    assign wr   = valid_i && write_i;

    // Key register: start latch and write-access lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_o <= 1'b0;
            wr_en     <= 1'b0;
        end else if (wr && addr == A_KEY) begin
            case (wdata_i)
                KEY_START:  started_o <= 1'b1;
                KEY_UNLOCK: wr_en     <= 1'b1;
                default:    wr_en     <= 1'b0;
            endcase
        end
    end

    assign presc_load_o  = wr && addr == A_PRESC  && wr_en;
    assign reload_load_o = wr && addr == A_RELOAD && wr_en;
    assign kick_load_o   = wr && addr == A_KEY    && wdata_i == KEY_KICK;

    // Readback multiplexer.
    always_comb begin
        case (addr)
            A_PRESC:  rdata_o = KEY_W'(presc_q_i);
            A_RELOAD: rdata_o = KEY_W'(reload_q_i);
            A_STATUS: rdata_o = KEY_W'({rl_busy_i, ps_busy_i});
            default:  rdata_o = '0;
        endcase
    end

    // R5: once started, stays started until reset.
    a_r5_start_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        started_o |=> started_o);

    // R3: a prescaler write while locked changes nothing.
    a_r3_locked_presc: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_PRESC && !wr_en) |=> $stable(presc_q_i));
endmodule

// File: rtl/slowwdg_core.sv
// Slow-domain prescaler and down counter. Fires a one-cycle request when the count
// expires, then reloads. A refresh has priority over an expiry in the same cycle.
// Assumes run_i is a synchronized level that never falls while out of reset.
module slowwdg_core #(
    parameter int CODE_W   = 3,
    parameter int MAX_CODE = 6,
    parameter int RELOAD_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic [CODE_W-1:0]   code_i,
    input  logic                code_upd_i,
    input  logic [RELOAD_W-1:0] reload_i,
    input  logic                reload_upd_i,
    input  logic                kick_upd_i,
    input  logic                kick_dat_i,
    output logic                fire_o
);
    localparam int                PRE_W = MAX_CODE + 2;
    localparam logic [CODE_W-1:0] MAXC  = CODE_W'(MAX_CODE);

    logic                run_d;
    logic [PRE_W-1:0]    pre;
    logic [PRE_W-1:0]    pre_top;
    logic [CODE_W-1:0]   sat;
    logic [RELOAD_W-1:0] cnt;
    logic                tick;
    logic                kick;

    // Saturate the code and form the divider terminal value (ratio - 1).
    always_comb begin
        sat     = (code_i > MAXC) ? MAXC : code_i;
        pre_top = ~({PRE_W{1'b1}} << (int'(sat) + 2));
    end

    assign tick = pre >= pre_top;
    assign kick = kick_upd_i && kick_dat_i;

    // Divider and counter update, with refresh taking priority over expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_d  <= 1'b0;
            pre    <= '0;
            cnt    <= '0;
            fire_o <= 1'b0;
        end else begin
            run_d  <= run_i;
            fire_o <= 1'b0;
            if (run_i && !run_d) begin
                cnt <= reload_i;
                pre <= '0;
            end else if (run_i) begin
                if (kick) begin
                    cnt <= reload_i;
                    pre <= '0;
                end else if (tick) begin
                    pre <= '0;
                    if (cnt == '0) begin
                        fire_o <= 1'b1;
                        cnt    <= reload_i;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end else if (code_upd_i) begin
                    pre <= '0;
                end else begin
                    pre <= pre + 1'b1;
                end
            end
        end
    end

    // R5: the synchronized run level never falls.
    a_r5_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> run_i);

    // R2: each request lasts a single slow cycle.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

    // R9: a refresh meeting an expiry tick suppresses the request.
    a_r9_refresh_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && run_d && kick && tick && cnt == '0) |=> !fire_o);

    // R4: taking up a new reload value does not disturb the running count.
    a_r4_reload_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && run_d && reload_upd_i && !kick && !tick) |=> cnt == $past(cnt));
endmodule

// File: rtl/slowclk_watchdog.sv
// Top of the slow-clock watchdog: bus register port, three domain-crossing transfers
// (prescaler code, reload value, refresh), start synchronizer and slow counter.
// Assumes bus_rst_n and slow_rst_n are asserted together.
module slowclk_watchdog
    import slowwdg_pkg::*;
#(
    parameter int CODE_W      = 3,
    parameter int MAX_CODE    = 6,
    parameter int RELOAD_W    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             bus_clk,
    input  logic             bus_rst_n,
    input  logic             slow_clk,
    input  logic             slow_rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [1:0]       bus_addr,
    input  logic [KEY_W-1:0] bus_wdata,
    output logic [KEY_W-1:0] bus_rdata,
    output logic             osc_keep_on,
    output logic             wdg_reset_req
);
    logic                presc_load, reload_load, kick_load, started;
    logic                ps_busy, rl_busy, kick_busy;
    logic [CODE_W-1:0]   presc_q, code_s;
    logic [RELOAD_W-1:0] reload_q, reload_s;
    logic                kick_q, kick_s;
    logic                ps_upd, rl_upd, kick_upd;
    logic                run_s;

    slowwdg_regs #(.CODE_W(CODE_W), .RELOAD_W(RELOAD_W)) u_regs (
        .clk(bus_clk), .rst_n(bus_rst_n),
        .valid_i(bus_valid), .write_i(bus_write), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata),
        .presc_q_i(presc_q), .reload_q_i(reload_q),
        .ps_busy_i(ps_busy), .rl_busy_i(rl_busy),
        .presc_load_o(presc_load), .reload_load_o(reload_load),
        .kick_load_o(kick_load), .started_o(started)
    );

    slowwdg_xfer #(.W(CODE_W), .RST_VAL('0), .STAGES(SYNC_STAGES)) u_presc_x (
        .a_clk(bus_clk), .a_rst_n(bus_rst_n), .load_i(presc_load),
        .data_i(bus_wdata[CODE_W-1:0]), .busy_o(ps_busy), .hold_o(presc_q),
        .b_clk(slow_clk), .b_rst_n(slow_rst_n), .upd_o(ps_upd), .data_o(code_s)
    );

    slowwdg_xfer #(.W(RELOAD_W), .RST_VAL('1), .STAGES(SYNC_STAGES)) u_reload_x (
        .a_clk(bus_clk), .a_rst_n(bus_rst_n), .load_i(reload_load),
        .data_i(bus_wdata[RELOAD_W-1:0]), .busy_o(rl_busy), .hold_o(reload_q),
        .b_clk(slow_clk), .b_rst_n(slow_rst_n), .upd_o(rl_upd), .data_o(reload_s)
    );

    // Refresh travels as a one-bit transfer; a refresh in flight absorbs a repeat.
    slowwdg_xfer #(.W(1), .RST_VAL(1'b0), .STAGES(SYNC_STAGES)) u_kick_x (
        .a_clk(bus_clk), .a_rst_n(bus_rst_n), .load_i(kick_load),
        .data_i(1'b1), .busy_o(kick_busy), .hold_o(kick_q),
        .b_clk(slow_clk), .b_rst_n(slow_rst_n), .upd_o(kick_upd), .data_o(kick_s)
    );

    slowwdg_sync #(.W(1), .STAGES(SYNC_STAGES)) u_run_sync (
        .clk(slow_clk), .rst_n(slow_rst_n), .d(started), .q(run_s)
    );

    slowwdg_core #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .RELOAD_W(RELOAD_W)) u_core (
        .clk(slow_clk), .rst_n(slow_rst_n), .run_i(run_s),
        .code_i(code_s), .code_upd_i(ps_upd),
        .reload_i(reload_s), .reload_upd_i(rl_upd),
        .kick_upd_i(kick_upd), .kick_dat_i(kick_s),
        .fire_o(wdg_reset_req)
    );

    assign osc_keep_on = started;

    // R6: the refresh transfer only ever carries a set bit once used.
    a_r6_kick_payload: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        kick_busy |-> kick_q);
endmodule

// File: tb/tb_slowclk_watchdog.sv
module tb_slowclk_watchdog;
    timeunit 1ns;
    timeprecision 100ps;

    logic        bus_clk = 1'b0;
    logic        slow_clk = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        slow_rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        osc_keep_on;
    logic        wdg_reset_req;

    always #2.5  bus_clk  = ~bus_clk;
    always #18.5 slow_clk = ~slow_clk;

    slowclk_watchdog dut (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .slow_clk(slow_clk),
        .slow_rst_n(slow_rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .osc_keep_on(osc_keep_on), .wdg_reset_req(wdg_reset_req)
    );

    int          tests = 0;
    int          fails = 0;
    bit          done = 0;
    bit          peeking = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    int          per_q[$];
    string       ptag = "";
    int          skip = 0;
    longint      scyc = 0;
    longint      last = 0;
    int          pulse_cnt = 0;
    bit          gap_chk = 0;
    int          gap_min = 0;
    logic [15:0] e_rd;
    string       t_rd;
    int          e_per;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: compare each scoreboarded read at the middle of its access cycle.
    always @(negedge bus_clk) begin
        if (bus_valid && !bus_write && !peeking && exp_q.size() > 0) begin
            e_rd = exp_q.pop_front();
            t_rd = tag_q.pop_front();
            check(bus_rdata == e_rd, t_rd, bus_rdata, e_rd);
        end
    end

    // Monitor: measure slow-cycle gaps between reset-request pulses.
    always @(negedge slow_clk) begin
        scyc++;
        if (wdg_reset_req) begin
            pulse_cnt++;
            if (gap_chk)
                check(scyc - last >= gap_min, "R9 gap never shorter than period", scyc - last, gap_min);
            if (skip > 0) begin
                skip--;
            end else if (per_q.size() > 0) begin
                e_per = per_q.pop_front();
                check(scyc - last == e_per, ptag, scyc - last, e_per);
            end
            last = scyc;
        end
    end

    task automatic bwr(input logic [1:0] a, input logic [15:0] d);
        @(posedge bus_clk); #1;
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(posedge bus_clk); #1;
        bus_valid = 0; bus_write = 0;
    endtask

    // Driver: push the expected read value, then perform the read.
    task automatic brd(input logic [1:0] a, input logic [15:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge bus_clk); #1;
        bus_valid = 1; bus_write = 0; bus_addr = a;
        @(posedge bus_clk); #1;
        bus_valid = 0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] v);
        peeking = 1;
        @(posedge bus_clk); #1;
        bus_valid = 1; bus_write = 0; bus_addr = a;
        @(negedge bus_clk);
        v = bus_rdata;
        @(posedge bus_clk); #1;
        bus_valid = 0;
        peeking = 0;
    endtask

    task automatic settle();
        logic [15:0] v;
        v = 16'hFFFF;
        while (v != 16'd0) peek(2'd3, v);
    endtask

    // Driver: expect n pulse gaps of length p after two pulses of run-in.
    task automatic expect_per(input int p, input int n, input string tag);
        ptag = tag;
        skip = 2;
        for (int i = 0; i < n; i++) per_q.push_back(p);
        while (per_q.size() != 0) @(negedge slow_clk);
    endtask

    task automatic wait_pulse();
        int c;
        c = pulse_cnt;
        while (pulse_cnt == c) @(posedge bus_clk);
    endtask

    initial begin
        repeat (190000) @(posedge bus_clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired (R1..R9 sequence) actual=hung expected=complete");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int c0;
        repeat (4) @(posedge slow_clk);
        @(posedge bus_clk); #1;
        bus_rst_n = 1; slow_rst_n = 1;
        repeat (4) @(posedge bus_clk);

        // R8: reset state
        brd(2'd1, 16'h0000, "R8 reset prescaler code");
        brd(2'd2, 16'h0FFF, "R8 reset reload");
        brd(2'd3, 16'h0000, "R8 reset status");
        check(osc_keep_on == 1'b0, "R8 osc_keep_on low at reset", osc_keep_on, 0);
        repeat (100) @(posedge slow_clk);
        check(pulse_cnt == 0, "R8 no pulses while idle", pulse_cnt, 0);

        // R3: writes ignored while locked
        bwr(2'd2, 16'h0005);
        bwr(2'd1, 16'h0002);
        brd(2'd2, 16'h0FFF, "R3 locked reload write ignored");
        brd(2'd1, 16'h0000, "R3 locked prescaler write ignored");

        // R4: busy flags after accepted writes
        bwr(2'd0, 16'h5555);
        bwr(2'd2, 16'h0003);
        brd(2'd3, 16'h0002, "R4 reload busy after write");
        settle();
        bwr(2'd1, 16'h0000);
        brd(2'd3, 16'h0001, "R4 prescaler busy after write");
        settle();
        brd(2'd2, 16'h0003, "R8 reload readback");

        // R4: a second write while busy is dropped
        bwr(2'd2, 16'h0009);
        bwr(2'd2, 16'h000A);
        settle();
        brd(2'd2, 16'h0009, "R4 write during busy ignored");
        bwr(2'd2, 16'h0003);
        settle();

        // R7: unknown key clears write access only
        bwr(2'd0, 16'h1234);
        bwr(2'd2, 16'h0007);
        brd(2'd2, 16'h0003, "R7 unknown key relocks");
        check(osc_keep_on == 1'b0, "R7 unknown key does not start", osc_keep_on, 0);

        // R5 + R2: start and period 4*(3+1)
        bwr(2'd0, 16'h5555);
        bwr(2'd0, 16'hCCCC);
        check(osc_keep_on == 1'b1, "R5 osc_keep_on after start", osc_keep_on, 1);
        expect_per(16, 3, "R2 period code0 reload3");

        // R1: ratios
        bwr(2'd1, 16'h0001);
        settle();
        expect_per(32, 2, "R1 period code1 reload3");
        bwr(2'd1, 16'h0007);
        settle();
        bwr(2'd2, 16'h0001);
        settle();
        expect_per(512, 2, "R1 code7 saturates to 256");
        bwr(2'd1, 16'h0003);
        settle();
        expect_per(64, 2, "R1 period code3 reload1");

        // R5: nothing stops it
        bwr(2'd0, 16'h0000);
        bwr(2'd0, 16'hFFFF);
        bwr(2'd0, 16'h5555);
        bwr(2'd0, 16'h1234);
        check(osc_keep_on == 1'b1, "R5 osc_keep_on stays high", osc_keep_on, 1);
        expect_per(64, 2, "R5 pulses continue after key writes");

        // R6: timely refreshes hold off the pulse
        bwr(2'd0, 16'h5555);
        bwr(2'd1, 16'h0000);
        settle();
        bwr(2'd2, 16'd63);
        settle();
        bwr(2'd0, 16'hAAAA);
        repeat (20) @(posedge slow_clk);
        c0 = pulse_cnt;
        for (int i = 0; i < 12; i++) begin
            bwr(2'd0, 16'hAAAA);
            repeat (120) @(posedge slow_clk);
        end
        check(pulse_cnt == c0, "R6 no pulse under refresh", pulse_cnt, c0);
        bwr(2'd2, 16'h0005);
        brd(2'd2, 16'd63, "R6 refresh clears write access");
        expect_per(256, 2, "R6 pulses resume without refresh");

        // R9: sweep refresh timing across a short period
        bwr(2'd0, 16'h5555);
        bwr(2'd2, 16'h0003);
        settle();
        expect_per(16, 1, "R9 setup period");
        gap_min = 16;
        gap_chk = 1;
        for (int k = 0; k < 24; k++) begin
            wait_pulse();
            repeat (k * 5) @(posedge bus_clk);
            bwr(2'd0, 16'hAAAA);
        end
        expect_per(16, 2, "R9 period after sweep");
        gap_chk = 0;

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule